// File: doc/BRIEF.md
# Video sync field parity detector

This block watches the horizontal and vertical sync pulses of a video signal and works out, for every field, whether it is even or odd. To do so it measures the time between the leading edge of vertical sync and the horizontal sync leading edge closest to it. If that horizontal edge sits within 12 us of the vertical edge, on either side, the field is even. If it comes 20 to 44 us after the vertical edge, the field is odd. Any other offset means the parity cannot be decided.

The block also measures the width of every pulse on both sync inputs and flags those that fall outside their windows. Both sync inputs pass through a two-flop synchroniser and a three-sample deglitcher first. All timing is counted in half-microsecond ticks, which a divider derives from the reference clock using the `TICKS_PER_US` parameter. Counters saturate at their maximum rather than wrap.

A vertical pulse of legal width produces a one-clock field-start strobe at its trailing edge, and the parity outputs are updated in that same clock. The error flags stay set until software clears them through write-one-to-clear inputs.

Top module: `sync_parity_det`

## Requirements
- R1: After synchronisation, a level on either sync input that lasts fewer than 3 reference clocks is ignored. It causes no strobe, no error and no change to any output.
- R2: The width of each horizontal pulse is counted in half-microsecond ticks. The pulse is legal if the count is at least 11 and less than 25, which is about 5.5 us to 12.5 us to within half a microsecond. Otherwise `h_width_err` is set at the pulse's trailing edge.
- R3: The width of each vertical pulse is counted in half-microsecond ticks. The pulse is legal if the count is at least 300 and less than 3000 (0.15 ms to 1.5 ms). Otherwise `v_width_err` is set at the pulse's trailing edge.
- R4: A field is classified as even (`field_odd`=0, `parity_unknown`=0) in two cases. The first is a horizontal leading edge no more than 12 us before the vertical leading edge. The second is a first horizontal leading edge after the vertical leading edge that arrives no more than 12 us after it.
- R5: A field is classified as odd (`field_odd`=1, `parity_unknown`=0) if no horizontal leading edge came within 12 us before the vertical leading edge and the first one after it arrives 20 to 44 us later.
- R6: Any other offset sets `parity_unknown`=1 and leaves `field_odd` holding its previous value. This covers a first horizontal edge between 12 and 20 us after the vertical edge, one more than 44 us after it, and none at all.
- R7: `field_start` goes high for exactly one clock at the trailing edge of a legal vertical pulse. `field_odd` and `parity_unknown` change only in that clock.
- R8: A vertical pulse of illegal width produces no `field_start` and leaves `field_odd` and `parity_unknown` unchanged.
- R9: The error flags are sticky. `h_err_clr`=1 clears `h_width_err` and `v_err_clr`=1 clears `v_width_err`; neither clear affects the other flag. A new error in the same clock as a clear keeps the flag set.
- R10: Reset (`rst_n`=0) drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, active high, asynchronous |
| vsync_in | input | 1 | Vertical sync, active high, asynchronous |
| h_err_clr | input | 1 | Write-one-to-clear for h_width_err |
| v_err_clr | input | 1 | Write-one-to-clear for v_width_err |
| field_odd | output | 1 | Parity of the last classified field, 1 = odd |
| parity_unknown | output | 1 | Last legal field could not be classified |
| field_start | output | 1 | One-clock strobe at the end of a legal vertical pulse |
| h_width_err | output | 1 | Sticky: a horizontal pulse was out of its window |
| v_width_err | output | 1 | Sticky: a vertical pulse was out of its window |

## Verification
The bench places the horizontal edge ahead of the vertical edge and behind it, and puts it in the gap between the two windows and past the odd window. A design that looked only forward, or that cleared parity on an undecidable field, would report the wrong parity, or a parity where the field should be marked unknown. It drives pulse widths just inside and just outside each window, including vertical pulses that are too short and too long. A design with an off-by-one window, or one that still strobes on an illegal vertical pulse, would raise or miss errors and strobes. Two-clock glitches check that the deglitcher rejects them instead of counting them as runt pulses. Separate clears check that each write-one-to-clear input touches only its own flag.

// File: rtl/spd_pkg.sv
package spd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,   // waiting for a vertical leading edge
        ST_SEEK,   // vertical high, waiting for the first horizontal edge
        ST_HOLD    // decision taken, waiting for the vertical trailing edge
    } spd_state_e;

    typedef enum logic [1:0] {
        CL_EVEN,
        CL_ODD,
        CL_UNK
    } spd_class_e;
endpackage

// File: rtl/spd_tick.sv
module spd_tick #(
    parameter int TICKS_PER_US = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int HALF = (TICKS_PER_US / 2 < 1) ? 1 : TICKS_PER_US / 2;
    localparam int CW   = (HALF < 2) ? 1 : $clog2(HALF);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/spd_cond.sv
module spd_cond #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [1:0]        sync_q;
    logic [STAGES-1:0] hist;
    logic              all1, all0;

    assign all1 = &hist;
    assign all0 = ~|hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            hist   <= '0;
            lvl    <= 1'b0;
            rise   <= 1'b0;
            fall   <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], din};
            hist   <= {hist[STAGES-2:0], sync_q[1]};
            rise   <= all1 && !lvl;
            fall   <= all0 && lvl;
            if (all1)      lvl <= 1'b1;
            else if (all0) lvl <= 1'b0;
        end
    end
endmodule

// File: rtl/spd_satcnt.sv
module spd_satcnt #(
    parameter int W          = 8,
    parameter bit RESET_FULL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= RESET_FULL ? '1 : '0;
        else if (clr)               cnt <= '0;
        else if (inc && cnt != '1)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sync_parity_det.sv
module sync_parity_det
    import spd_pkg::*;
#(
    parameter int TICKS_PER_US = 12,
    parameter int DEGLITCH     = 3,
    parameter int H_MIN_HUS    = 11,
    parameter int H_MAX_HUS    = 25,
    parameter int V_MIN_HUS    = 300,
    parameter int V_MAX_HUS    = 3000,
    parameter int EVEN_HUS     = 24,
    parameter int ODD_LO_HUS   = 40,
    parameter int ODD_HI_HUS   = 88
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_in,
    input  logic vsync_in,
    input  logic h_err_clr,
    input  logic v_err_clr,
    output logic field_odd,
    output logic parity_unknown,
    output logic field_start,
    output logic h_width_err,
    output logic v_width_err
);
    localparam int HTOP = (H_MAX_HUS > ODD_HI_HUS) ? H_MAX_HUS : ODD_HI_HUS;
    localparam int HW   = $clog2(HTOP + 2);
    localparam int VW   = $clog2(V_MAX_HUS + 2);
    localparam logic [HW-1:0] H_MIN_C  = HW'(H_MIN_HUS);
    localparam logic [HW-1:0] H_MAX_C  = HW'(H_MAX_HUS);
    localparam logic [HW-1:0] EVEN_C   = HW'(EVEN_HUS);
    localparam logic [HW-1:0] ODD_LO_C = HW'(ODD_LO_HUS);
    localparam logic [HW-1:0] ODD_HI_C = HW'(ODD_HI_HUS);
    localparam logic [VW-1:0] V_MIN_C  = VW'(V_MIN_HUS);
    localparam logic [VW-1:0] V_MAX_C  = VW'(V_MAX_HUS);

    logic          tick;
    logic [1:0]    raw, lvl, rise, fall;
    logic          h_lvl, h_rise, h_fall, v_lvl, v_rise, v_fall;
    logic [HW-1:0] h_wcnt, h_age, off_cnt;
    logic [VW-1:0] v_wcnt;
    spd_state_e    state, state_nx;
    spd_class_e    cls, post_cls;
    logic          h_win_ok, v_win_ok, pre_even, timeout, field_ok;

    spd_tick #(.TICKS_PER_US(TICKS_PER_US)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    // channel 0: horizontal, channel 1: vertical
    assign raw = {vsync_in, hsync_in};
    for (genvar g = 0; g < 2; g++) begin : g_cond
        spd_cond #(.STAGES(DEGLITCH)) u_cond (
            .clk(clk), .rst_n(rst_n), .din(raw[g]),
            .lvl(lvl[g]), .rise(rise[g]), .fall(fall[g])
        );
    end
    assign {v_lvl, h_lvl}   = lvl;
    assign {v_rise, h_rise} = rise;
    assign {v_fall, h_fall} = fall;

    spd_satcnt #(.W(HW)) u_hwidth (
        .clk(clk), .rst_n(rst_n), .clr(h_rise), .inc(tick && h_lvl), .cnt(h_wcnt)
    );
    spd_satcnt #(.W(HW), .RESET_FULL(1'b1)) u_hage (
        .clk(clk), .rst_n(rst_n), .clr(h_rise), .inc(tick), .cnt(h_age)
    );
    spd_satcnt #(.W(HW)) u_offset (
        .clk(clk), .rst_n(rst_n), .clr(v_rise), .inc(tick && state == ST_SEEK), .cnt(off_cnt)
    );
    spd_satcnt #(.W(VW)) u_vwidth (
        .clk(clk), .rst_n(rst_n), .clr(v_rise), .inc(tick && v_lvl), .cnt(v_wcnt)
    );

    assign h_win_ok = (h_wcnt >= H_MIN_C) && (h_wcnt < H_MAX_C);
    assign v_win_ok = (v_wcnt >= V_MIN_C) && (v_wcnt < V_MAX_C);
    assign pre_even = h_rise || (h_age <= EVEN_C);
    assign timeout  = off_cnt > ODD_HI_C;
    assign field_ok = v_fall && v_win_ok && (state == ST_HOLD);

    always_comb begin
        if (off_cnt <= EVEN_C)                                post_cls = CL_EVEN;
        else if (off_cnt >= ODD_LO_C && off_cnt <= ODD_HI_C) post_cls = CL_ODD;
        else                                                  post_cls = CL_UNK;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (v_rise) state_nx = pre_even ? ST_HOLD : ST_SEEK;
            ST_SEEK: begin
                if (v_fall)                  state_nx = ST_IDLE;
                else if (h_rise || timeout)  state_nx = ST_HOLD;
            end
            ST_HOLD: if (v_fall) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs and decision register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cls            <= CL_EVEN;
            field_odd      <= 1'b0;
            parity_unknown <= 1'b0;
            field_start    <= 1'b0;
            h_width_err    <= 1'b0;
            v_width_err    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (v_rise && pre_even) cls <= CL_EVEN;
                ST_SEEK: begin
                    if (!v_fall && h_rise)  cls <= post_cls;
                    else if (!v_fall && timeout) cls <= CL_UNK;
                end
                ST_HOLD: ;
                default: ;
            endcase

            field_start <= field_ok;
            if (field_ok) begin
                if (cls == CL_UNK) begin
                    parity_unknown <= 1'b1;
                end else begin
                    parity_unknown <= 1'b0;
                    field_odd      <= (cls == CL_ODD);
                end
            end

            if (h_fall && !h_win_ok) h_width_err <= 1'b1;
            else if (h_err_clr)      h_width_err <= 1'b0;

            if (v_fall && !v_win_ok) v_width_err <= 1'b1;
            else if (v_err_clr)      v_width_err <= 1'b0;
        end
    end
endmodule

// File: rtl/spd_checker.sv
module spd_checker (
    input logic clk,
    input logic rst_n,
    input logic field_start,
    input logic field_odd,
    input logic parity_unknown,
    input logic h_width_err,
    input logic v_width_err,
    input logic h_err_clr,
    input logic v_err_clr
);
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> !field_start);

    a_r7_parity_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field_odd) |-> field_start);

    a_r7_unknown_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(parity_unknown) |-> field_start);

    a_r6_hold_on_unknown: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(parity_unknown) |-> $stable(field_odd));

    a_r9_h_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (h_width_err && !h_err_clr) |=> h_width_err);

    a_r9_v_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (v_width_err && !v_err_clr) |=> v_width_err);
endmodule

bind sync_parity_det spd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .field_start(field_start), .field_odd(field_odd),
    .parity_unknown(parity_unknown), .h_width_err(h_width_err),
    .v_width_err(v_width_err), .h_err_clr(h_err_clr), .v_err_clr(v_err_clr)
);

// File: tb/sync_parity_det_test.sv
module sync_parity_det_test;
    // 4 reference clocks per microsecond: 1 half-us tick = 2 clocks
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsync_in = 1'b0, vsync_in = 1'b0, h_err_clr = 1'b0, v_err_clr = 1'b0;
    logic field_odd, parity_unknown, field_start, h_width_err, v_width_err;
    int   errors = 0, checks = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    sync_parity_det #(.TICKS_PER_US(4)) uut (
        .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .h_err_clr(h_err_clr), .v_err_clr(v_err_clr), .field_odd(field_odd),
        .parity_unknown(parity_unknown), .field_start(field_start),
        .h_width_err(h_width_err), .v_width_err(v_width_err)
    );

    // columns: h offset, h width, v width (clocks), odd, unknown, strobes, herr, verr
    localparam int NV = 17;
    localparam int VEC [NV][8] = '{
        '{   0, 44, 4000, 0, 0, 1, 0, 0 },  // coincident: even
        '{ 128, 44, 4000, 1, 0, 1, 0, 0 },  // 32 us: odd
        '{  64, 44, 4000, 1, 1, 1, 0, 0 },  // 16 us gap: unknown, hold odd
        '{ -40, 44, 4000, 0, 0, 1, 0, 0 },  // 10 us before: even
        '{ 200, 44, 4000, 0, 1, 1, 0, 0 },  // 50 us: unknown, hold even
        '{  88, 44, 4000, 1, 0, 1, 0, 0 },  // 22 us: odd
        '{  40, 44, 4000, 0, 0, 1, 0, 0 },  // 10 us after: even
        '{ 168, 44, 4000, 1, 0, 1, 0, 0 },  // 42 us: odd
        '{ -56, 44, 4000, 1, 1, 1, 0, 0 },  // 14 us before, none after: unknown
        '{   0, 16, 4000, 0, 0, 1, 1, 0 },  // h 4 us: error
        '{   0, 56, 4000, 0, 0, 1, 1, 0 },  // h 14 us: error
        '{ 128, 24, 4000, 1, 0, 1, 0, 0 },  // h 6 us: legal
        '{   0, 48, 4000, 0, 0, 1, 0, 0 },  // h 12 us: legal
        '{ 128, 44,  400, 0, 0, 0, 0, 1 },  // v 0.1 ms: error, no strobe
        '{ 128, 44, 6400, 0, 0, 0, 0, 1 },  // v 1.6 ms: error, no strobe
        '{ 128, 44,  800, 1, 0, 1, 0, 0 },  // v 0.2 ms: legal
        '{   0, 44, 5600, 0, 0, 1, 0, 0 }   // v 1.4 ms: legal
    };

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic run_field(input int off, input int hw, input int vw, output int starts);
        int base, hs, len, tail;
        base = 60;
        hs = base + off;
        tail = (vw > off + hw) ? vw : off + hw;
        len = base + tail + 300;
        starts = 0;
        for (int t = 0; t < len; t++) begin
            @(negedge clk);
            if (field_start) starts++;
            hsync_in = (t >= hs) && (t < hs + hw);
            vsync_in = (t >= base) && (t < base + vw);
        end
    endtask

    task automatic pulse_clear(input bit h, input bit v);
        @(negedge clk);
        h_err_clr = h;
        v_err_clr = v;
        @(negedge clk);
        h_err_clr = 1'b0;
        v_err_clr = 1'b0;
    endtask

    task automatic glitch(input bit on_v, output int starts);
        starts = 0;
        @(negedge clk);
        if (on_v) vsync_in = 1'b1; else hsync_in = 1'b1;
        repeat (2) @(negedge clk);
        vsync_in = 1'b0;
        hsync_in = 1'b0;
        for (int t = 0; t < 60; t++) begin
            @(negedge clk);
            if (field_start) starts++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R10 watchdog expired: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int st;
        string ptag;
        repeat (5) @(negedge clk);
        // R10: reset state
        check("R10", "field_odd at reset", field_odd, 0);
        check("R10", "parity_unknown at reset", parity_unknown, 0);
        check("R10", "field_start at reset", field_start, 0);
        check("R10", "h_width_err at reset", h_width_err, 0);
        check("R10", "v_width_err at reset", v_width_err, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_field(VEC[i][0], VEC[i][1], VEC[i][2], st);
            if (VEC[i][5] == 0)      ptag = "R8";
            else if (VEC[i][4] != 0) ptag = "R6";
            else if (VEC[i][3] != 0) ptag = "R5";
            else                     ptag = "R4";
            check(ptag, $sformatf("vec %0d field_odd", i), field_odd, VEC[i][3]);
            check(ptag, $sformatf("vec %0d parity_unknown", i), parity_unknown, VEC[i][4]);
            check(VEC[i][5] != 0 ? "R7" : "R8", $sformatf("vec %0d strobes", i), st, VEC[i][5]);
            check("R2", $sformatf("vec %0d h_width_err", i), h_width_err, VEC[i][6]);
            check("R3", $sformatf("vec %0d v_width_err", i), v_width_err, VEC[i][7]);
            pulse_clear(1'b1, 1'b1);
        end

        // R1: short glitches are rejected
        glitch(1'b1, st);
        check("R1", "v glitch strobes", st, 0);
        check("R1", "v glitch v_width_err", v_width_err, 0);
        check("R1", "v glitch field_odd", field_odd, 0);
        glitch(1'b0, st);
        check("R1", "h glitch h_width_err", h_width_err, 0);

        // R9: sticky flags and separate clears
        run_field(0, 16, 400, st);
        check("R9", "h err set", h_width_err, 1);
        check("R9", "v err set", v_width_err, 1);
        pulse_clear(1'b0, 1'b1);
        check("R9", "h err kept after v clear", h_width_err, 1);
        check("R9", "v err cleared", v_width_err, 0);
        repeat (10) @(negedge clk);
        check("R9", "h err still sticky", h_width_err, 1);
        pulse_clear(1'b1, 1'b0);
        check("R9", "h err cleared", h_width_err, 0);

        // R10: reset after an odd field returns outputs to 0
        run_field(128, 44, 4000, st);
        check("R5", "odd before reset", field_odd, 1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", "field_odd after reset", field_odd, 0);
        check("R10", "parity_unknown after reset", parity_unknown, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule